// File: doc/BRIEF.md
# Wire-Order CRC-32 Generator and Checker

This block computes a 32-bit cyclic redundancy check over a byte stream, treating the bits in the order a serial line sends them: bit 0 of each byte first. It does not reverse the bits of each byte. It keeps a right-shifting remainder register and uses the polynomial in its bit-reversed form, so a short error burst on the wire stays a short burst in the division. One byte is taken per clock cycle. Strobes mark the first and last byte of a message.

In transmit mode, the last byte of a message makes the block compute the final remainder and invert it. It then hands the result out as four checksum bytes through a ready/valid output, low byte first, ready to be appended to the message. In receive mode, the message and its four appended checksum bytes run through the same register. One cycle after the last byte, the block reports whether the remainder equals the fixed residue of the polynomial.

The register starts at all ones, so leading zero bytes change the result. Inverting the checksum means that zero bytes appended to a good codeword make it bad.

Top module: `crc32_wire`

## Requirements
- R1: A synchronous active-high reset leaves outValid, outLast, chkDone and chkGood low and presets the remainder register to all ones.
- R2: Each byte with inValid high is absorbed in one cycle. Its bits go through the division from bit 0 to bit 7, using the reflected polynomial with a right shift. With the default polynomial, the ASCII bytes "123456789" give the checksum 0xE3069283.
- R3: The remainder starts at all ones, so the one-byte message 0x00 and the two-byte message 0x00 0x00 give different checksums.
- R4: In transmit mode (txMode high with the end byte), the checksum is the bitwise inverse of the remainder after the end byte.
- R5: The checksum leaves as four bytes, least significant byte first, on outData with outValid. A byte advances only on a cycle where outValid and outReady are both high. While outReady is low, outValid and outData stay unchanged. outLast is high with the fourth byte only.
- R6: A byte with inSom high restarts the remainder from all ones before that byte is absorbed, even in the middle of a message.
- R7: In receive mode (txMode low with the end byte), chkDone is high for exactly the one cycle after the end byte. chkGood is registered at the same time and is high only when the remainder after the end byte equals the residue.
- R8: In receive mode, any error burst of 32 bits or fewer in the wire-order bit stream of message plus checksum makes chkGood low.
- R9: While inValid is low, inData, inSom and inEom have no effect on the remainder or on any output.
- R10: Appending a zero byte to a good codeword makes chkGood low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | inData holds a byte to absorb this cycle |
| inData | input | 8 | Message byte |
| inSom | input | 1 | First byte of a message: restart from all ones |
| inEom | input | 1 | Last byte of a message |
| txMode | input | 1 | Sampled with the end byte: 1 emits the checksum, 0 checks the residue |
| outReady | input | 1 | Consumer accepts the checksum byte on outData |
| outValid | output | 1 | A checksum byte is on outData |
| outData | output | 8 | Checksum byte, low byte first |
| outLast | output | 1 | outData holds the fourth checksum byte |
| chkDone | output | 1 | One-cycle pulse: a receive check has completed |
| chkGood | output | 1 | Result of the latest receive check |

## Verification
The bench attacks bit order and the preset. A design that shifted the wrong way or took bit 7 first would miss the known "123456789" value. A design that started from zero would give the same checksum for one zero byte and two zero bytes. Stalling the output with outReady low shows whether bytes are dropped or reordered, and whether outLast lands on the wrong byte. Bursts of up to 32 flipped wire-order bits are placed at the start, in the middle, across the checksum boundary and at the end of a codeword; a design that missed any of them would report a corrupted frame as good. Other tests cover a mid-message restart, idle cycles carrying junk strobes, and a trailing zero byte; a design that ignored the restart, let a strobe act while invalid, or skipped the final inversion would report a bad residue as good.

// File: rtl/crc32_wire_pkg.sv
package crc32_wire_pkg;

  // Strobes from control to datapath, one set per cycle.
  typedef struct packed {
    logic absorb;    // take inData into the remainder
    logic seedOnes;  // start this byte from the all-ones preset
    logic endMsg;    // this byte closes the message
    logic capture;   // latch the inverted remainder for sending
    logic check;     // compare the remainder with the residue
    logic shiftSum;  // consumer took the current checksum byte
  } crcCtrl_t;

endpackage

// File: rtl/crc32_wire_dp.sv
module crc32_wire_dp
  import crc32_wire_pkg::*;
#(
  parameter int CRC_W = 32,
  parameter int BYTE_W = 8,
  parameter logic [CRC_W-1:0] POLY = 32'h82F63B78,
  parameter logic [CRC_W-1:0] RESIDUE = 32'hB798B438
) (
  input  logic              clk,
  input  logic              rst,
  input  crcCtrl_t          ctrl,
  input  logic [BYTE_W-1:0] inData,
  output logic [BYTE_W-1:0] sumByte,
  output logic              chkGood
);

  localparam logic [CRC_W-1:0] ONES = {CRC_W{1'b1}};

  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] sumReg;
  logic [CRC_W-1:0] stage [0:BYTE_W];

  assign stage[0] = ctrl.seedOnes ? ONES : crcReg;

  // One reflected division step per bit, bit 0 of the byte first.
  for (genvar i = 0; i < BYTE_W; i++) begin : g_step
    logic [CRC_W-1:0] mixed;
    assign mixed = stage[i] ^ {{(CRC_W-1){1'b0}}, inData[i]};
    assign stage[i+1] = mixed[0] ? ((mixed >> 1) ^ POLY) : (mixed >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crcReg <= ONES;
    end else if (ctrl.absorb) begin
      crcReg <= ctrl.endMsg ? ONES : stage[BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumReg <= '0;
    end else if (ctrl.capture) begin
      sumReg <= ~stage[BYTE_W];
    end else if (ctrl.shiftSum) begin
      sumReg <= sumReg >> BYTE_W;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chkGood <= 1'b0;
    end else if (ctrl.check) begin
      chkGood <= (stage[BYTE_W] == RESIDUE);
    end
  end

  assign sumByte = sumReg[BYTE_W-1:0];

endmodule

// File: rtl/crc32_wire_ctrl.sv
module crc32_wire_ctrl
  import crc32_wire_pkg::*;
#(
  parameter int CRC_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  input  logic     inSom,
  input  logic     inEom,
  input  logic     txMode,
  input  logic     outReady,
  output crcCtrl_t ctrl,
  output logic     outValid,
  output logic     outLast,
  output logic     chkDone
);

  localparam int SUM_BYTES = CRC_W / BYTE_W;
  localparam int CNT_W = $clog2(SUM_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SUM_BYTES);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] sumLeft;

  always_comb begin
    ctrl.absorb   = inValid;
    ctrl.seedOnes = inValid & inSom;
    ctrl.endMsg   = inValid & inEom;
    ctrl.capture  = inValid & inEom & txMode;
    ctrl.check    = inValid & inEom & ~txMode;
    ctrl.shiftSum = outValid & outReady;
  end

  assign outValid = (sumLeft != '0);
  assign outLast  = (sumLeft == CNT_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      sumLeft <= '0;
    end else if (ctrl.capture) begin
      sumLeft <= CNT_FULL;
    end else if (ctrl.shiftSum) begin
      sumLeft <= sumLeft - CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chkDone <= 1'b0;
    end else begin
      chkDone <= ctrl.check;
    end
  end

endmodule

// File: rtl/crc32_wire.sv
module crc32_wire
  import crc32_wire_pkg::*;
#(
  parameter int CRC_W = 32,
  parameter int BYTE_W = 8,
  parameter logic [CRC_W-1:0] POLY = 32'h82F63B78,
  parameter logic [CRC_W-1:0] RESIDUE = 32'hB798B438
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inSom,
  input  logic              inEom,
  input  logic              txMode,
  input  logic              outReady,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outLast,
  output logic              chkDone,
  output logic              chkGood
);

  crcCtrl_t ctrl;

  crc32_wire_ctrl #(
    .CRC_W(CRC_W),
    .BYTE_W(BYTE_W)
  ) u_ctrl (
    .clk(clk),
    .rst(rst),
    .inValid(inValid),
    .inSom(inSom),
    .inEom(inEom),
    .txMode(txMode),
    .outReady(outReady),
    .ctrl(ctrl),
    .outValid(outValid),
    .outLast(outLast),
    .chkDone(chkDone)
  );

  crc32_wire_dp #(
    .CRC_W(CRC_W),
    .BYTE_W(BYTE_W),
    .POLY(POLY),
    .RESIDUE(RESIDUE)
  ) u_dp (
    .clk(clk),
    .rst(rst),
    .ctrl(ctrl),
    .inData(inData),
    .sumByte(outData),
    .chkGood(chkGood)
  );

endmodule

// File: rtl/crc32_wire_chk.sv
module crc32_wire_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inEom,
  input logic              txMode,
  input logic              outReady,
  input logic              outValid,
  input logic [BYTE_W-1:0] outData,
  input logic              outLast,
  input logic              chkDone,
  input logic              chkGood
);

  logic rstSeen;

  always_ff @(posedge clk) begin
    rstSeen <= rst;
    if (rstSeen === 1'b1) begin
      AST_RESET_IDLE: assert (!outValid && !outLast && !chkDone && !chkGood); // R1
    end
  end

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    outLast |-> outValid); // R5

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady && !(inValid && inEom && txMode))
      |=> (outValid && $stable(outData))); // R5

  AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && outLast && !(inValid && inEom && txMode))
      |=> !outValid); // R5

  AST_DONE_AFTER_RX_END: assert property (@(posedge clk) disable iff (rst)
    chkDone |-> $past(inValid && inEom && !txMode)); // R7

  AST_RX_END_GIVES_DONE: assert property (@(posedge clk) disable iff (rst)
    (inValid && inEom && !txMode) |=> chkDone); // R7

endmodule

bind crc32_wire crc32_wire_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .inValid(inValid),
  .inEom(inEom),
  .txMode(txMode),
  .outReady(outReady),
  .outValid(outValid),
  .outData(outData),
  .outLast(outLast),
  .chkDone(chkDone),
  .chkGood(chkGood)
);

// File: tb/crc32_wire_tb.sv
module crc32_wire_tb;

  // Normal (non-reflected) form of the default polynomial, used by the model.
  localparam logic [31:0] NORM_POLY = 32'h1EDC6F41;

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // Left-shifting division, fed bit 0 of each byte first.
  function automatic logic [31:0] stepByte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] x;
    logic fb;
    x = c;
    for (int i = 0; i < 8; i++) begin
      fb = x[31] ^ b[i];
      x = x << 1;
      if (fb) x = x ^ NORM_POLY;
    end
    return x;
  endfunction

  function automatic logic [31:0] tbResidue();
    logic [31:0] c;
    logic [31:0] s;
    c = 32'hFFFFFFFF;
    c = stepByte(c, 8'h31);
    c = stepByte(c, 8'h32);
    s = ~rev32(c);
    for (int j = 0; j < 4; j++) c = stepByte(c, s[j*8 +: 8]);
    return rev32(c);
  endfunction

  localparam logic [31:0] TB_RESIDUE = tbResidue();

  // {gap between bytes, length, bytes with byte 0 in bits 7:0}
  localparam int NVEC = 6;
  localparam logic [69:0] VEC [0:NVEC-1] = '{
    {2'd0, 4'd1, 64'h00},
    {2'd0, 4'd2, 64'h0000},
    {2'd0, 4'd1, 64'hFF},
    {2'd1, 4'd4, 64'hDEADBEEF},
    {2'd2, 4'd8, 64'h0123456789ABCDEF},
    {2'd0, 4'd5, 64'h8080808080}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic inSom = 1'b0;
  logic inEom = 1'b0;
  logic txMode = 1'b0;
  logic outReady = 1'b1;
  logic outValid;
  logic [7:0] outData;
  logic outLast;
  logic chkDone;
  logic chkGood;

  always #2 clk = ~clk;

  crc32_wire #(.RESIDUE(TB_RESIDUE)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inSom(inSom),
    .inEom(inEom), .txMode(txMode), .outReady(outReady), .outValid(outValid),
    .outData(outData), .outLast(outLast), .chkDone(chkDone), .chkGood(chkGood)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] mbuf [0:31];
  logic [7:0] cw [0:31];
  logic [31:0] sums [0:NVEC-1];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modelSum(input int first, input int n);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = first; i < first + n; i++) c = stepByte(c, mbuf[i]);
    return ~rev32(c);
  endfunction

  // Sends mbuf[0..n-1]; ends at the negedge after the end byte's edge.
  task automatic sendBuf(input int n, input bit tx, input int somAt, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData = mbuf[i];
      inSom = (i == 0) || (i == somAt);
      inEom = (i == n - 1);
      txMode = tx;
      if (i != n - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          inValid = 1'b0;        // R9: junk while invalid
          inData = 8'h5A + 8'(g);
          inSom = 1'b1;
          inEom = 1'b1;
          txMode = ~tx;
        end
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    inSom = 1'b0;
    inEom = 1'b0;
  endtask

  task automatic collectSum(input string req, output logic [31:0] s);
    s = '0;
    for (int j = 0; j < 4; j++) begin
      chk({req, " valid"}, {31'b0, outValid}, 32'd1);
      chk({req, " last"}, {31'b0, outLast}, {31'b0, j == 3});
      s[j*8 +: 8] = outData;
      @(negedge clk);
    end
    chk({req, " drained"}, {31'b0, outValid}, 32'd0);
  endtask

  task automatic rxCheck(input string req, input int n, input bit expGood);
    sendBuf(n, 1'b0, -1, 0);
    chk({req, " done"}, {31'b0, chkDone}, 32'd1);
    chk({req, " good"}, {31'b0, chkGood}, {31'b0, expGood});
    @(negedge clk);
    chk({req, " done pulse"}, {31'b0, chkDone}, 32'd0);
  endtask

  task automatic loadCodeword(input int n);
    logic [31:0] s;
    s = modelSum(0, n);
    for (int j = 0; j < 4; j++) mbuf[n + j] = s[j*8 +: 8];
    for (int i = 0; i < n + 4; i++) cw[i] = mbuf[i];
  endtask

  task automatic burstTest(input int n, input int pos, input int len);
    for (int i = 0; i < n + 4; i++) mbuf[i] = cw[i];
    for (int k = pos; k < pos + len; k++) begin
      if (k == pos || k == pos + len - 1 || ((k - pos) % 3) == 0)
        mbuf[k / 8][k % 8] = ~mbuf[k / 8][k % 8];
    end
    rxCheck("R8 burst", n + 4, 1'b0);
  endtask

  initial begin
    logic [31:0] got;
    int len;
    int gap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: quiet after reset
    chk("R1 outValid", {31'b0, outValid}, 32'd0);
    chk("R1 outLast", {31'b0, outLast}, 32'd0);
    chk("R1 chkDone", {31'b0, chkDone}, 32'd0);
    chk("R1 chkGood", {31'b0, chkGood}, 32'd0);

    // Table walk: R2/R4 transmit checksum, then R7 receive check of the codeword.
    for (int v = 0; v < NVEC; v++) begin
      gap = int'(VEC[v][69:68]);
      len = int'(VEC[v][67:64]);
      for (int i = 0; i < len; i++) mbuf[i] = VEC[v][i*8 +: 8];
      sendBuf(len, 1'b1, -1, gap);
      collectSum("R5 table", got);
      chk("R2 R4 table checksum", got, modelSum(0, len));
      sums[v] = got;
      for (int j = 0; j < 4; j++) mbuf[len + j] = got[j*8 +: 8];
      rxCheck("R7 table codeword", len + 4, 1'b1);
    end
    chk("R3 zero-length sensitivity", {31'b0, sums[0] != sums[1]}, 32'd1);

    // R2: known check value, with R5 stall before draining.
    for (int i = 0; i < 9; i++) mbuf[i] = 8'h31 + 8'(i);
    outReady = 1'b0;
    sendBuf(9, 1'b1, -1, 0);
    for (int k = 0; k < 3; k++) begin
      chk("R5 stall valid", {31'b0, outValid}, 32'd1);
      chk("R5 stall data", {24'b0, outData}, 32'h83);
      @(negedge clk);
    end
    outReady = 1'b1;
    collectSum("R5 after stall", got);
    chk("R2 known value", got, 32'hE3069283);

    // R9: idle junk between bytes of the known message leaves the result alone.
    sendBuf(9, 1'b1, -1, 3);
    collectSum("R9 gaps", got);
    chk("R9 gaps checksum", got, 32'hE3069283);

    // R6: restart in the middle of a message.
    for (int i = 0; i < 6; i++) mbuf[i] = 8'hC0 + 8'(i * 7);
    sendBuf(6, 1'b1, 3, 0);
    collectSum("R6 restart", got);
    chk("R6 restart checksum", got, modelSum(3, 3));

    // R8: bursts up to 32 wire bits over an 8-byte codeword (96 bits).
    for (int i = 0; i < 8; i++) mbuf[i] = 8'h11 * 8'(i + 1);
    loadCodeword(8);
    rxCheck("R7 base codeword", 12, 1'b1);
    burstTest(8, 0, 1);
    burstTest(8, 5, 32);
    burstTest(8, 40, 17);
    burstTest(8, 60, 32);
    burstTest(8, 90, 6);

    // R10: trailing zero byte breaks the codeword.
    for (int i = 0; i < 12; i++) mbuf[i] = cw[i];
    mbuf[12] = 8'h00;
    rxCheck("R10 trailing zero", 13, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule